// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a shift register with the outcomes of the most recently resolved branches. Those outcome bits are joined with low-order PC bits to choose one saturating counter from a table. Each PC-selected entry therefore holds one counter for every possible history pattern. The recent global behaviour decides which counter of the entry gives the prediction and which one is trained.

The lookup side is purely combinational. A fetch stage presents a branch PC and receives a taken/not-taken guess in the same cycle. It also receives the history value that was used to form that guess. The pipeline carries this history value alongside the branch. When the branch resolves, the pipeline returns the PC, the real outcome and the carried history. The block then trains exactly the counter that made the prediction, and it shifts the outcome into the global history.

The table has no tags, so branches whose PC index bits match share counters. The default shape uses two history bits and two-bit counters in 256 entries, which is 1024 counters in total. A single history bit gives the narrowest correlating variant. The design requires `HIST_W` of at least 1 and `CTR_W` of at least 2.

Top module: `corr_bpred`

## Requirements
- R1: `pred_taken_o` is combinational and equals the most significant bit of the counter at flat index `{lookup_pc_i[9:2], history}` (entry times 4 plus history). A value of 1 means taken.
- R2: After reset every counter holds 01 (weakly not-taken) and the history is 00. Every lookup therefore predicts not-taken, and `pred_hist_o` reads 0.
- R3: On each cycle with `upd_valid_i` high, the history shifts left and `upd_taken_i` enters at bit 0. The history holds when no update occurs. The current history is visible on `pred_hist_o`.
- R4: An update modifies only the counter at `{upd_pc_i[9:2], upd_hist_i}`, using the supplied history rather than the current one. All other counters are unchanged.
- R5: On an update, a taken outcome increments the counter, saturating at 3. A not-taken outcome decrements it, saturating at 0.
- R6: A counter saturated at 3 still predicts taken after one not-taken update. It predicts not-taken after a second one.
- R7: There is no tag check. PC bits above bit 9 and bits [1:0] do not affect which counter is selected.
- R8: When a lookup and an update select the same counter in one cycle, the lookup returns the value from before the update.
- R9: Different history values select different counters within the same PC entry. Training under one history does not move the prediction made under another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_pc_i | input | 32 | PC of the branch being predicted |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_hist_o | output | 2 | Global history used for this prediction |
| upd_valid_i | input | 1 | A resolved branch is presented this cycle |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |
| upd_hist_i | input | 2 | History value carried from prediction time |

## Verification
The hardest case to reach is a counter that belongs to a history pattern other than the live one. Such a counter can be trained through the supplied update history, but it can only be read back after the global history has been steered to that pattern by further updates. The stimulus trains one PC under a chosen history while the live history differs. It then issues updates on an unrelated PC whose outcomes walk the history to each pattern in turn, and compares the predictions. A long random phase confined to a few colliding PCs, with random update histories and many same-cycle lookup/update collisions, is compared every clock against a behavioural model of the whole counter array.

// File: rtl/bp_pkg.sv
package bp_pkg;
  // Saturating up/down step for a counter with ceiling maxv.
  function automatic int unsigned sat_step(int unsigned v, int unsigned maxv, logic up);
    if (up) return (v == maxv) ? v : v + 1;
    else    return (v == 0)    ? v : v - 1;
  endfunction
endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned HIST_W = 2
) (
  input  logic [PC_W-1:0]         pc_i,
  input  logic [HIST_W-1:0]       hist_i,
  output logic [IDX_W+HIST_W-1:0] idx_o
);
  logic unused_pc;
  assign unused_pc = ^{pc_i[PC_W-1:IDX_W+2], pc_i[1:0]};
  // word-aligned PCs; history picks the counter within the entry
  assign idx_o = {pc_i[IDX_W+1:2], hist_i};
endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W:0] shifted;
  assign shifted = {hist_o, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_o <= '0;
    else if (shift_i) hist_o <= shifted[HIST_W-1:0];
  end

  // R3
  ghist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(hist_o));
  // R3
  ghist_ins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> hist_o[0] == $past(bit_i));
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int unsigned CTR_W = 2,
  parameter int unsigned AW    = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    rd_idx_i,
  output logic [CTR_W-1:0] rd_ctr_o,
  input  logic             we_i,
  input  logic [AW-1:0]    wr_idx_i,
  input  logic             wr_up_i
);
  import bp_pkg::*;
  localparam int unsigned DEPTH = 2 ** AW;
  localparam int unsigned CTR_MAX = 2 ** CTR_W - 1;
  localparam logic [CTR_W-1:0] CTR_INIT = {1'b0, {(CTR_W-1){1'b1}}};

  logic [CTR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (we_i) begin
      mem[wr_idx_i] <= CTR_W'(sat_step(int'(mem[wr_idx_i]), CTR_MAX, wr_up_i));
    end
  end

  // read returns stored value, so a same-cycle write is not visible yet
  assign rd_ctr_o = mem[rd_idx_i];

  // R4
  ctr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (rd_idx_i != $past(rd_idx_i)) || $stable(rd_ctr_o));
  // R4
  ctr_other_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_idx_i != rd_idx_i) |=> (rd_idx_i != $past(rd_idx_i)) || $stable(rd_ctr_o));
  // R5
  ctr_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_up_i && wr_idx_i == rd_idx_i && rd_ctr_o != CTR_W'(CTR_MAX))
    |=> (rd_idx_i != $past(rd_idx_i)) || (rd_ctr_o == $past(rd_ctr_o) + 1'b1));
  // R5
  ctr_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wr_up_i && wr_idx_i == rd_idx_i && rd_ctr_o == '0)
    |=> (rd_idx_i != $past(rd_idx_i)) || (rd_ctr_o == '0));
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned HIST_W  = 2,
  parameter int unsigned CTR_W   = 2,
  parameter int unsigned ENTRIES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   lookup_pc_i,
  output logic              pred_taken_o,
  output logic [HIST_W-1:0] pred_hist_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [HIST_W-1:0] upd_hist_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned AW    = IDX_W + HIST_W;

  logic [HIST_W-1:0] ghist;
  logic [AW-1:0]     rd_idx, wr_idx;
  logic [CTR_W-1:0]  rd_ctr;

  bp_ghist #(.HIST_W(HIST_W)) u_ghist (
    .clk_i, .rst_ni, .shift_i(upd_valid_i), .bit_i(upd_taken_i), .hist_o(ghist)
  );

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_rd_index (
    .pc_i(lookup_pc_i), .hist_i(ghist), .idx_o(rd_idx)
  );

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_wr_index (
    .pc_i(upd_pc_i), .hist_i(upd_hist_i), .idx_o(wr_idx)
  );

  bp_ctr_table #(.CTR_W(CTR_W), .AW(AW)) u_table (
    .clk_i, .rst_ni, .rd_idx_i(rd_idx), .rd_ctr_o(rd_ctr),
    .we_i(upd_valid_i), .wr_idx_i(wr_idx), .wr_up_i(upd_taken_i)
  );

  assign pred_taken_o = rd_ctr[CTR_W-1];
  assign pred_hist_o  = ghist;

  // R1
  pred_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({pred_taken_o, pred_hist_o}));
endmodule

// File: tb/sim_corr_bpred.sv
`timescale 1ns/1ps
module sim_corr_bpred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lookup_pc = '0;
  logic        pred_taken;
  logic [1:0]  pred_hist;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [1:0]  upd_hist = '0;

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          done = 1'b0;

  int model_ctr [1024];
  int model_hist;

  always #4 clk = ~clk;

  corr_bpred u0 (
    .clk_i(clk), .rst_ni(rst_n), .lookup_pc_i(lookup_pc), .pred_taken_o(pred_taken),
    .pred_hist_o(pred_hist), .upd_valid_i(upd_valid), .upd_pc_i(upd_pc),
    .upd_taken_i(upd_taken), .upd_hist_i(upd_hist)
  );

  function automatic int midx(logic [31:0] pc, int h);
    return int'(pc[9:2]) * 4 + h;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare against model, then clock and update model
  task automatic step(string tag, logic [31:0] lpc, logic uv, logic [31:0] upc,
                      logic ut, int uh);
    @(negedge clk);
    lookup_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_hist = 2'(uh);
    #1;
    check({tag, " pred"}, int'(pred_taken), int'(model_ctr[midx(lpc, model_hist)] >= 2));
    check({tag, " hist"}, int'(pred_hist), model_hist);
    @(posedge clk);
    if (uv) begin
      int k = midx(upc, uh);
      if (ut) begin if (model_ctr[k] < 3) model_ctr[k]++; end
      else    begin if (model_ctr[k] > 0) model_ctr[k]--; end
      model_hist = ((model_hist << 1) | int'(ut)) & 3;
    end
  endtask

  task automatic look(string tag, logic [31:0] lpc);
    step(tag, lpc, 1'b0, '0, 1'b0, 0);
  endtask

  task automatic train(string tag, logic [31:0] pc, logic t);
    step(tag, pc, 1'b1, pc, t, model_hist);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) model_ctr[i] = 1;
    model_hist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R2: reset state
    for (int i = 0; i < 8; i++) look("R2", 32'h100 + 32'(i * 36));
    check("R2 direct", int'(pred_taken), 0);

    // R5: saturate up then down
    for (int i = 0; i < 5; i++) train("R5 up", 32'h40, 1'b1);
    // R3: history is now 11 after taken updates
    look("R3", 32'h40);
    check("R3 direct", int'(pred_hist), 3);
    for (int i = 0; i < 5; i++) train("R5 down", 32'h40, 1'b0);

    // R6: saturate at history 00, then one miss keeps taken, two flip
    for (int i = 0; i < 4; i++) step("R6 train", 32'h80, 1'b1, 32'h80, 1'b1, 0);
    // history is 11; walk it back to 00 via unrelated PC
    train("R3 walk", 32'h3f0, 1'b0);
    train("R3 walk", 32'h3f0, 1'b0);
    look("R6 strong", 32'h80);
    check("R6 strong direct", int'(pred_taken), 1);
    step("R6 miss1", 32'h3f4, 1'b1, 32'h80, 1'b0, 0);
    step("R3 walk", 32'h3f4, 1'b1, 32'h3f8, 1'b0, 0);
    step("R3 walk", 32'h3f4, 1'b1, 32'h3f8, 1'b0, 0);
    look("R6 after one", 32'h80);
    check("R6 one miss direct", int'(pred_taken), 1);
    step("R6 miss2", 32'h3f4, 1'b1, 32'h80, 1'b0, 0);
    step("R3 walk", 32'h3f4, 1'b1, 32'h3f8, 1'b0, 0);
    step("R3 walk", 32'h3f4, 1'b1, 32'h3f8, 1'b0, 0);
    look("R6 after two", 32'h80);
    check("R6 two miss direct", int'(pred_taken), 0);

    // R7: aliasing through upper and low PC bits
    for (int i = 0; i < 3; i++) step("R7 train", 32'h200, 1'b1, 32'h200, 1'b1, model_hist);
    look("R7 alias hi", 32'h0000_0600);
    look("R7 alias lo", 32'h0000_0203);
    look("R7 alias far", 32'hABC0_0200);

    // R8: same counter looked up while updated
    step("R8 collide", 32'h300, 1'b1, 32'h300, 1'b1, model_hist);
    step("R8 collide", 32'h300, 1'b1, 32'h300, 1'b1, 1);
    look("R8 after", 32'h300);

    // R9/R4: train PC 0x1c0 under history 10 only, then visit each history
    for (int i = 0; i < 3; i++) step("R9 train", 32'h1c0, 1'b1, 32'h1c0, 1'b1, 2);
    for (int h = 0; h < 4; h++) begin
      step("R4 steer", 32'h1c0, 1'b1, 32'h3fc, h[1], 0);
      step("R4 steer", 32'h1c0, 1'b1, 32'h3fc, h[0], 0);
      look("R9 per-history", 32'h1c0);
      check("R9 direct", int'(pred_taken), int'(h == 2));
    end

    // R1, R4, R5: random traffic over colliding PCs
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] lp = {$urandom_range(0, 3), 20'h0, 4'($urandom_range(0, 3)), 6'h0, 2'($urandom_range(0, 3))};
      logic [31:0] up = {$urandom_range(0, 3), 20'h0, 4'($urandom_range(0, 3)), 6'h0, 2'($urandom_range(0, 3))};
      step("R1 R4 random", lp, 1'($urandom_range(0, 1)), up, 1'($urandom_range(0, 1)),
           int'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule